// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises an interrupt toward the CPU after a programmed number of video scanlines. The CPU programs it through four write-only registers. It sees the top three address bits, address bit 0 and an 8-bit data byte. A separate one-cycle `line_tick` strobe marks each scanline; the logic that derives that strobe from the video fetch address is outside this block. The interrupt output is a level. It stays high until the CPU acknowledges it.

Each scanline tick decrements a 9-bit signed counter. When the counter crosses from zero to minus one while interrupts are enabled, the request is raised. A reload value written by the CPU is held in a latch. It reaches the counter in one of three ways: through an explicit reload write, through a deferred load when interrupts are enabled, or at once if the write falls inside the short window that follows an acknowledge and lasts until the next scanline tick.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write takes effect only when `cpu_we` is high and `cpu_addr_hi` is 3'b110 or 3'b111. Code 3'b110 with `cpu_a0`=0 is the latch write, 3'b110 with `cpu_a0`=1 the reload write, 3'b111 with `cpu_a0`=0 the disable write, and 3'b111 with `cpu_a0`=1 the enable write. Writes to any other address change nothing.
- R2: A latch write stores the data byte and marks a deferred load as pending. If the post-acknowledge window is open, the byte is also copied into the counter at once and the pending mark is cleared.
- R3: A reload write copies the latch into the counter.
- R4: A disable write clears the enable flag, drops `irq_req` on the next clock edge and opens the post-acknowledge window.
- R5: An enable write sets the enable flag. If a deferred load is pending, it also copies the latch into the counter; the pending mark stays set.
- R6: Every `line_tick` closes the post-acknowledge window. A non-negative counter decrements by one. When the counter goes from 0 to -1 with the enable flag set, `irq_req` is high from the next clock edge.
- R7: A negative counter stays at -1 on further ticks and raises no new request, even after interrupts are enabled again.
- R8: Once high, `irq_req` stays high through latch, reload and enable writes and through ticks. Only a disable write or reset clears it.
- R9: Reset sets the counter and latch to zero and clears the enable flag, the pending mark, the window and `irq_req`.
- R10: When a counter-loading write and a `line_tick` arrive in the same cycle, the write's value is loaded and that tick's decrement is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr_hi | input | 3 | CPU address bits 15..13 |
| cpu_a0 | input | 1 | CPU address bit 0 |
| cpu_wdata | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| irq_req | output | 1 | Level interrupt request, active high |

## Verification
The embedded assertions check four rules on every cycle: the request falls after each acknowledge, it holds until then, it rises only on an enabled expiry, and the counter never goes below -1. They also check that the post-acknowledge window opens and closes on the correct events. Other behaviour cannot be seen at a single cycle and is shown only by the bench's scenarios. This includes the interval between enable and interrupt for every reload value from 0 to 255, and the difference between an immediate load and a deferred one. It also covers how a load write and a tick that arrive together are resolved, and the address decode.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  parameter int unsigned DATA_W = 8;
  localparam int unsigned CNT_W = DATA_W + 1;

  typedef struct packed {
    logic set_latch;
    logic reload;
    logic disarm;
    logic arm;
  } irq_sel_t;
endpackage

// File: rtl/irq_reset_sync.sv
module irq_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import scanline_irq_pkg::*;
(
  input  logic       cpu_we,
  input  logic [2:0] cpu_addr_hi,
  input  logic       cpu_a0,
  output irq_sel_t   sel
);
  localparam logic [2:0] PAGE_LOAD = 3'b110;
  localparam logic [2:0] PAGE_CTRL = 3'b111;

  logic hit_load;
  logic hit_ctrl;

  always_comb begin
    hit_load      = cpu_we && (cpu_addr_hi == PAGE_LOAD);
    hit_ctrl      = cpu_we && (cpu_addr_hi == PAGE_CTRL);
    sel.set_latch = hit_load && !cpu_a0;
    sel.reload    = hit_load &&  cpu_a0;
    sel.disarm    = hit_ctrl && !cpu_a0;
    sel.arm       = hit_ctrl &&  cpu_a0;
  end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter
  import scanline_irq_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  irq_sel_t      sel,
  input  logic [DW-1:0] wdata,
  input  logic          line_tick,
  output logic          expire
);
  localparam int unsigned CW = DW + 1;

  logic [DW-1:0] latch_q, latch_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          win_q, win_d;
  logic          latch_en, cnt_en, pend_en, win_en;
  logic          is_neg, is_zero, load_now;
  logic [CW-1:0] latch_ext, wdata_ext;

  always_comb begin
    latch_ext = {1'b0, latch_q};
    wdata_ext = {1'b0, wdata};
    is_neg    = cnt_q[CW-1];
    is_zero   = (cnt_q == '0);
    load_now  = (sel.set_latch && win_q) || sel.reload || (sel.arm && pend_q);

    latch_en  = sel.set_latch;
    latch_d   = wdata;

    pend_en   = sel.set_latch;
    pend_d    = !win_q;

    win_en    = sel.disarm || line_tick;
    win_d     = sel.disarm;

    cnt_en    = load_now || (line_tick && !is_neg);
    if (sel.set_latch && win_q) cnt_d = wdata_ext;
    else if (load_now)          cnt_d = latch_ext;
    else                        cnt_d = cnt_q - CW'(1);

    expire    = line_tick && !load_now && is_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      if (pend_en)  pend_q  <= pend_d;
      if (win_en)   win_q   <= win_d;
    end
  end

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[CW-1] |-> (cnt_q == '1)); // R7
  AST_WIN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    sel.disarm |=> win_q); // R4
  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && !sel.disarm) |=> !win_q); // R6
endmodule

// File: rtl/irq_req_flag.sv
module irq_req_flag
  import scanline_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_sel_t sel,
  input  logic     expire,
  output logic     irq_req
);
  logic en_q, en_d, en_en;
  logic irq_q, irq_d, irq_en;

  always_comb begin
    en_en  = sel.disarm || sel.arm;
    en_d   = sel.arm;
    irq_en = sel.disarm || (expire && en_q);
    irq_d  = !sel.disarm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (en_en)  en_q  <= en_d;
      if (irq_en) irq_q <= irq_d;
    end
  end

  assign irq_req = irq_q;

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    sel.disarm |=> !irq_q); // R4
  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !sel.disarm) |=> irq_q); // R8
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(expire && en_q)); // R6
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scanline_irq_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic [2:0]    cpu_addr_hi,
  input  logic          cpu_a0,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          line_tick,
  output logic          irq_req
);
  logic     rst_core_n;
  irq_sel_t sel;
  logic     expire;

  irq_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_async_n(rst_n), .rst_sync_n(rst_core_n)
  );

  irq_wr_decode u_dec (
    .cpu_we(cpu_we), .cpu_addr_hi(cpu_addr_hi), .cpu_a0(cpu_a0), .sel(sel)
  );

  irq_line_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_core_n), .sel(sel), .wdata(cpu_wdata),
    .line_tick(line_tick), .expire(expire)
  );

  irq_req_flag u_flag (
    .clk(clk), .rst_n(rst_core_n), .sel(sel), .expire(expire), .irq_req(irq_req)
  );

  AST_NO_DECODE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irq_req && !(cpu_we && cpu_addr_hi == 3'b111)) |=> irq_req); // R1
endmodule

// File: tb/scanline_irq_counter_bench.sv
module scanline_irq_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_we = 1'b0;
  logic [2:0] cpu_addr_hi = 3'b000;
  logic       cpu_a0 = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic       line_tick = 1'b0;
  logic       irq_req;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  scanline_irq_counter u_scanline_irq_counter (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr_hi(cpu_addr_hi),
    .cpu_a0(cpu_a0), .cpu_wdata(cpu_wdata), .line_tick(line_tick), .irq_req(irq_req)
  );

  task automatic check(input logic exp, input string req);
    vectors++;
    if (irq_req !== exp) begin
      miscompares++;
      $display("FAIL %s: irq_req actual=%0b expected=%0b at %0t", req, irq_req, exp, $time);
    end
  endtask

  task automatic cyc(input logic we, input logic [2:0] hi, input logic a0,
                     input logic [7:0] d, input logic tick);
    @(negedge clk);
    cpu_we = we; cpu_addr_hi = hi; cpu_a0 = a0; cpu_wdata = d; line_tick = tick;
    @(negedge clk);
    cpu_we = 1'b0; line_tick = 1'b0;
  endtask

  task automatic wr_latch(input logic [7:0] d);  cyc(1'b1, 3'b110, 1'b0, d, 1'b0); endtask
  task automatic wr_reload();                    cyc(1'b1, 3'b110, 1'b1, 8'h00, 1'b0); endtask
  task automatic wr_disarm();                    cyc(1'b1, 3'b111, 1'b0, 8'h00, 1'b0); endtask
  task automatic wr_arm();                       cyc(1'b1, 3'b111, 1'b1, 8'h00, 1'b0); endtask
  task automatic tick();                         cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b1); endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset();
    check(1'b0, "R9 reset state");

    // R9: reset clears enable and latch: counter 0 expires while disabled
    wr_latch(8'd7); wr_arm(); do_reset();
    tick(); check(1'b0, "R9 enable cleared by reset");
    wr_arm(); tick(); tick(); check(1'b0, "R9 pending cleared by reset");

    // R3/R5/R6 sweep over every reload value, deferred-load path
    for (int n = 0; n < 256; n++) begin
      wr_disarm(); check(1'b0, "R4 ack");
      tick();
      wr_latch(8'(n)); wr_arm();
      for (int k = 0; k < n; k++) begin
        tick(); check(1'b0, "R6 no early irq");
      end
      tick(); check(1'b1, "R6 irq on expiry");
    end

    // R8: request sticky through other writes and ticks
    wr_latch(8'd9); check(1'b1, "R8 hold after latch write");
    wr_reload();    check(1'b1, "R8 hold after reload");
    wr_arm();       check(1'b1, "R8 hold after enable");
    tick();         check(1'b1, "R8 hold after tick");
    // R1: writes outside the control pages do nothing
    cyc(1'b1, 3'b100, 1'b0, 8'h00, 1'b0); check(1'b1, "R1 page 100 ignored");
    cyc(1'b1, 3'b101, 1'b0, 8'h00, 1'b0); check(1'b1, "R1 page 101 ignored");
    cyc(1'b1, 3'b011, 1'b0, 8'h00, 1'b0); check(1'b1, "R1 page 011 ignored");
    cyc(1'b0, 3'b111, 1'b0, 8'h00, 1'b0); check(1'b1, "R1 no write strobe");
    wr_disarm(); check(1'b0, "R4 ack clears");

    // R2: immediate load inside window, pending cleared
    wr_latch(8'd5);            // window open: counter = 5
    tick();                    // closes window, counter 4
    wr_arm();                  // no pending: no reload
    for (int k = 0; k < 4; k++) begin
      tick(); check(1'b0, "R2 immediate load no early irq");
    end
    tick(); check(1'b1, "R2 immediate load expiry");

    // R7: negative counter holds, no re-raise
    wr_disarm(); wr_latch(8'd2);   // immediate load 2, disabled
    tick(); tick(); tick(); check(1'b0, "R7 disabled expiry silent");
    wr_arm();
    for (int k = 0; k < 5; k++) begin
      tick(); check(1'b0, "R7 negative counter holds");
    end

    // R10: reload coincides with tick, load wins
    wr_disarm(); wr_latch(8'd2);   // counter 2, no pending
    tick();                        // counter 1
    wr_arm();
    cyc(1'b1, 3'b110, 1'b1, 8'h00, 1'b1); // reload + tick: counter 2
    tick(); tick(); check(1'b0, "R10 load beat tick");
    tick(); check(1'b1, "R10 expiry after coincident load");

    // R5: enable with pending reloads latch over a running count
    wr_disarm(); tick();           // window closed
    wr_latch(8'd1);                // pending, counter unchanged (-1)
    wr_arm();                      // reload 1
    tick(); check(1'b0, "R5 pending reload count");
    tick(); check(1'b1, "R5 pending reload expiry");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule